// File: doc/BRIEF.md
# Tiled Block-Floating-Point Dot Product

This block computes the dot product of two vectors held in block floating point. One operand element is worth its signed fixed-point mantissa scaled by two to the power of the exponent its block shares. A tile is one beat on the input stream. It carries every lane of mantissas for both operands, one shared exponent per operand, and a flag that marks the final tile of a vector. Inside a tile the block multiplies lane by lane and sums the products in a wide integer accumulator. This needs no alignment, because all lanes of a tile share one scale. The tile's scale is simply the sum of the two operand exponents.

Alignment is done once per tile, not once per element. At each tile boundary the integer tile sum and its exponent are folded into a running floating-point partial sum. When the flagged final tile has been folded, the floating-point result is presented on a valid/ready output together with the raw integer sum of that final tile. The running sum is then cleared for the next vector.

In a matrix product, the left matrix would supply one exponent per row and the right matrix one per column. Each pairing of a row with a column becomes one stream of tiles into this block.

Top module: `bfp_tile_dot`

## Requirements
- R1: The integer sum of a tile is the exact sum over all lanes of the products of the two operands' two's complement mantissas. It is reported on `out_tile_sum` for the final tile of each vector.
- R2: The exponent of a tile is the sum of the two signed shared exponents of that tile.
- R3: The tile accumulator is 2×MW + ceil(log2(LANES)) bits wide. It never overflows, including when every lane holds the most negative mantissa in both operands.
- R4: To fold a nonzero tile into a nonzero running sum, both values are aligned to the larger of the two exponents. The value with the smaller exponent is arithmetically shifted right (rounding toward minus infinity) by the exponent difference, and then the two are added.
- R5: If the aligned sum does not fit the FW-bit signed running mantissa, it is shifted right arithmetically by one bit and the exponent is raised by one.
- R6: A tile whose integer sum is zero leaves the running mantissa and exponent unchanged, whatever its exponent is.
- R7: When the running sum is zero, a nonzero tile is taken over exactly, with its own exponent. Any fold whose result is zero sets the exponent to zero.
- R8: A tile accepted with `in_last` set produces `out_valid` two clock edges after the accepting edge. The running sum starts from zero for the tile that follows.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values.
- R10: After a synchronous active-low reset, `out_valid` is low, `in_ready` is high and the running sum is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A tile is offered |
| in_ready | output | 1 | The tile is taken on this edge |
| in_mant_a | input | LANES*MW | Mantissas of operand A, lane 0 in the low bits |
| in_mant_b | input | LANES*MW | Mantissas of operand B, lane 0 in the low bits |
| in_exp_a | input | EW | Shared signed exponent of operand A |
| in_exp_b | input | EW | Shared signed exponent of operand B |
| in_last | input | 1 | Final tile of the vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken |
| out_mant | output | FW | Signed mantissa of the result |
| out_exp | output | XW | Signed exponent of the result |
| out_tile_sum | output | ACCW | Raw integer sum of the final tile |

## Verification
The hardest behaviour to reach from the ports is the renormalising shift of the running mantissa. A single tile cannot fill the running mantissa, so the stimulus repeats twelve tiles of all-negative-extreme lanes at one exponent until the sum crosses the signed range. Cancellation to an exact zero is the second hard case, because only that outcome resets the exponent. It is reached by sending a tile and then its negation at the same scale. A zero tile sent with an unusual exponent in the middle of a vector shows that the exponent is ignored when the sum is zero. Held output backpressure while new tiles are offered exercises the stall.

// File: rtl/bfp_pkg.sv
// Package: shared helpers for the tiled block-floating-point dot product.
// Assumes widths are small enough for 32-bit elaboration arithmetic.
package bfp_pkg;

    // Width of an exact integer sum of LANES products of MW-bit mantissas
    function automatic int tile_acc_width(input int lanes, input int mw);
        return 2 * mw + $clog2(lanes);
    endfunction

endpackage

// File: rtl/bfp_lane_mul.sv
// Module: lane multipliers. Forms LANES signed products of two's complement
// mantissas in parallel. Assumes lane k occupies bits [k*MW +: MW].
module bfp_lane_mul #(
    parameter int LANES = 24,
    parameter int MW    = 8,
    localparam int PW   = 2 * MW
) (
    input  logic [LANES*MW-1:0] mant_a,
    input  logic [LANES*MW-1:0] mant_b,
    output logic [LANES*PW-1:0] prod
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PW-1:0] ax;
        logic signed [PW-1:0] bx;
        // sign-extend each mantissa to product width
        assign ax = {{MW{mant_a[g*MW+MW-1]}}, mant_a[g*MW +: MW]};
        assign bx = {{MW{mant_b[g*MW+MW-1]}}, mant_b[g*MW +: MW]};
        // exact product; the magnitude fits PW bits
        assign prod[g*PW +: PW] = ax * bx;
    end

endmodule

// File: rtl/bfp_tile_reduce.sv
// Module: tile reduction. Sums LANES signed products into an accumulator
// wide enough to hold any combination without overflow.
module bfp_tile_reduce #(
    parameter int LANES = 24,
    parameter int PW    = 16,
    parameter int ACCW  = 21
) (
    input  logic [LANES*PW-1:0] prod,
    output logic [ACCW-1:0]     tile_sum
);

    // sign-extend every product and add it to the running integer sum
    always_comb begin
        tile_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            tile_sum = tile_sum + {{(ACCW-PW){prod[i*PW+PW-1]}}, prod[i*PW +: PW]};
        end
    end

endmodule

// File: rtl/bfp_fp_fold.sv
// Module: floating-point fold. Adds one tile value (integer sum times two to
// the tile exponent) into the running mantissa/exponent pair. Aligns to the
// larger exponent with a saturated arithmetic right shift, then renormalises
// by one bit on overflow. Assumes the exponent never leaves XW bits.
module bfp_fp_fold #(
    parameter int FW   = 23,
    parameter int XW   = 12,
    parameter int ACCW = 21,
    parameter int TW   = 9
) (
    input  logic [FW-1:0]   run_m,
    input  logic [XW-1:0]   run_e,
    input  logic [ACCW-1:0] tile_s,
    input  logic [TW-1:0]   tile_e,
    output logic [FW-1:0]   new_m,
    output logic [XW-1:0]   new_e
);

    localparam logic [XW:0] SHMAX = (XW+1)'(FW - 1);

    logic signed [FW-1:0] t_x;
    logic signed [XW-1:0] te_x;
    logic signed [XW-1:0] big_e;
    logic        [XW:0]   d_run;
    logic        [XW:0]   d_tile;
    logic        [XW:0]   sh_run;
    logic        [XW:0]   sh_tile;
    logic signed [FW-1:0] a_al;
    logic signed [FW-1:0] b_al;
    logic signed [FW:0]   sum;
    logic signed [FW-1:0] m_n;
    logic signed [XW-1:0] e_n;

    // widen the tile operands to the running formats
    assign t_x  = {{(FW-ACCW){tile_s[ACCW-1]}}, tile_s};
    assign te_x = {{(XW-TW){tile_e[TW-1]}}, tile_e};

    // choose the common exponent and the shift each side needs
    always_comb begin
        if ($signed(run_e) >= te_x) begin
            big_e  = $signed(run_e);
            d_run  = '0;
            d_tile = {run_e[XW-1], run_e} - {te_x[XW-1], te_x};
        end else begin
            big_e  = te_x;
            d_run  = {te_x[XW-1], te_x} - {run_e[XW-1], run_e};
            d_tile = '0;
        end
        sh_run  = (d_run  > SHMAX) ? SHMAX : d_run;
        sh_tile = (d_tile > SHMAX) ? SHMAX : d_tile;
    end

    // align, add, renormalise by one bit if the sum left the signed range
    always_comb begin
        a_al = $signed(run_m) >>> sh_run;
        b_al = t_x >>> sh_tile;
        sum  = {a_al[FW-1], a_al} + {b_al[FW-1], b_al};
        if (sum[FW] != sum[FW-1]) begin
            m_n = sum[FW:1];
            e_n = big_e + XW'(1);
        end else begin
            m_n = sum[FW-1:0];
            e_n = big_e;
        end
        if (m_n == '0) e_n = '0;
    end

    // pick between bypass cases and the full fold
    always_comb begin
        if (tile_s == '0) begin
            new_m = run_m;
            new_e = run_e;
        end else if (run_m == '0) begin
            new_m = t_x;
            new_e = te_x;
        end else begin
            new_m = m_n;
            new_e = e_n;
        end
    end

endmodule

// File: rtl/bfp_tile_dot.sv
// Module: tiled block-floating-point dot product (top). Stage 1 registers
// the integer tile sum and tile exponent; stage 2 folds them into the
// running floating-point sum and releases the result on the final tile.
// Assumes one whole tile per input beat; the whole pipe stalls while a
// result waits on out_ready.
module bfp_tile_dot #(
    parameter int LANES = 24,
    parameter int MW    = 8,
    parameter int EW    = 8,
    parameter int GUARD = 2,
    localparam int ACCW = bfp_pkg::tile_acc_width(LANES, MW),
    localparam int FW   = ACCW + GUARD,
    localparam int XW   = EW + 4,
    localparam int TW   = EW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LANES*MW-1:0] in_mant_a,
    input  logic [LANES*MW-1:0] in_mant_b,
    input  logic [EW-1:0]       in_exp_a,
    input  logic [EW-1:0]       in_exp_b,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [FW-1:0]       out_mant,
    output logic [XW-1:0]       out_exp,
    output logic [ACCW-1:0]     out_tile_sum
);

    localparam int PW = 2 * MW;

    logic [LANES*PW-1:0] prod;
    logic [ACCW-1:0]     tile_sum;
    logic                adv;
    logic                s1_valid;
    logic                s1_last;
    logic [ACCW-1:0]     s1_sum;
    logic [TW-1:0]       s1_exp;
    logic [FW-1:0]       run_m;
    logic [XW-1:0]       run_e;
    logic [FW-1:0]       fold_m;
    logic [XW-1:0]       fold_e;

    bfp_lane_mul #(.LANES(LANES), .MW(MW)) u_mul (
        .mant_a (in_mant_a),
        .mant_b (in_mant_b),
        .prod   (prod)
    );

    bfp_tile_reduce #(.LANES(LANES), .PW(PW), .ACCW(ACCW)) u_red (
        .prod     (prod),
        .tile_sum (tile_sum)
    );

    bfp_fp_fold #(.FW(FW), .XW(XW), .ACCW(ACCW), .TW(TW)) u_fold (
        .run_m  (run_m),
        .run_e  (run_e),
        .tile_s (s1_sum),
        .tile_e (s1_exp),
        .new_m  (fold_m),
        .new_e  (fold_e)
    );

    // the pipe moves unless a result is waiting on the consumer
    assign adv      = !(out_valid && !out_ready);
    assign in_ready = adv;

    // stage 1: capture the tile's integer sum and summed exponent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_sum   <= '0;
            s1_exp   <= '0;
        end else if (adv) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_last <= in_last;
                s1_sum  <= tile_sum;
                s1_exp  <= {in_exp_a[EW-1], in_exp_a} + {in_exp_b[EW-1], in_exp_b};
            end
        end
    end

    // stage 2: fold into the running sum; release and clear on the final tile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_m        <= '0;
            run_e        <= '0;
            out_valid    <= 1'b0;
            out_mant     <= '0;
            out_exp      <= '0;
            out_tile_sum <= '0;
        end else if (adv) begin
            out_valid <= s1_valid && s1_last;
            if (s1_valid) begin
                if (s1_last) begin
                    out_mant     <= fold_m;
                    out_exp      <= fold_e;
                    out_tile_sum <= s1_sum;
                    run_m        <= '0;
                    run_e        <= '0;
                end else begin
                    run_m <= fold_m;
                    run_e <= fold_e;
                end
            end
        end
    end

endmodule

// File: rtl/bfp_tile_dot_chk.sv
// Module: property checker for bfp_tile_dot, attached by bind below.
module bfp_tile_dot_chk #(
    parameter int LANES = 24,
    parameter int MW    = 8,
    parameter int FW    = 23,
    parameter int XW    = 12,
    parameter int ACCW  = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_last,
    input logic            out_valid,
    input logic            out_ready,
    input logic [FW-1:0]   out_mant,
    input logic [XW-1:0]   out_exp,
    input logic [ACCW-1:0] out_tile_sum
);

    localparam longint SUM_MAX = longint'(LANES) * (64'sd1 <<< (2*MW-2));
    localparam longint SUM_MIN = -longint'(LANES) * (64'sd1 <<< (MW-1)) * ((64'sd1 <<< (MW-1)) - 1);

    // R9: a held result keeps every field and blocks input
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_tile_sum));

    // R9: no input is accepted while a result is held
    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R7: a zero result carries exponent zero
    p_zero_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_mant == '0 |-> out_exp == '0);

    // R8: a fresh result follows an accepted final tile by two edges
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_last, 2));

    // R3: reported tile sums stay inside the reachable product range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_tile_sum) <= SUM_MAX) && ($signed(out_tile_sum) >= SUM_MIN));

    // R10: reset leaves no result pending
    p_reset_r10: assert property (@(posedge clk) !rst_n |=> !out_valid);

endmodule

bind bfp_tile_dot bfp_tile_dot_chk #(
    .LANES(LANES), .MW(MW), .FW(FW), .XW(XW), .ACCW(ACCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_mant(out_mant), .out_exp(out_exp), .out_tile_sum(out_tile_sum)
);

// File: tb/tb_bfp_tile_dot.sv
module tb_bfp_tile_dot;

    localparam int LANES = 24;
    localparam int MW    = 8;
    localparam int EW    = 8;
    localparam int ACCW  = 2 * MW + $clog2(LANES);
    localparam int FW    = ACCW + 2;
    localparam int XW    = EW + 4;
    localparam longint MMAX = (64'sd1 <<< (FW-1)) - 1;
    localparam longint MMIN = -(64'sd1 <<< (FW-1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [LANES*MW-1:0] in_mant_a = '0;
    logic [LANES*MW-1:0] in_mant_b = '0;
    logic [EW-1:0]       in_exp_a = '0;
    logic [EW-1:0]       in_exp_b = '0;
    logic                in_last = 1'b0;
    logic                out_valid;
    logic                out_ready = 1'b1;
    logic [FW-1:0]       out_mant;
    logic [XW-1:0]       out_exp;
    logic [ACCW-1:0]     out_tile_sum;

    bfp_tile_dot #(.LANES(LANES), .MW(MW), .EW(EW)) dut (.*);

    always #4 clk = ~clk;

    int     n_run = 0;
    int     n_fail = 0;
    string  cur_req = "R10";
    logic [LANES*MW-1:0] ta = '0;
    logic [LANES*MW-1:0] tb = '0;

    // reference state
    bit     ms1_v = 0, ms1_last = 0;
    longint ms1_sum = 0;
    int     ms1_exp = 0;
    longint racc = 0;
    int     rexp = 0;
    bit     eov = 0;
    longint em = 0, et = 0;
    int     ee = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    function automatic void fold(input longint t, input int te);
        int e;
        longint a, b, s;
        if (t == 0) return;
        if (racc == 0) begin racc = t; rexp = te; return; end
        e = (rexp > te) ? rexp : te;
        a = racc >>> (((e - rexp) > 62) ? 62 : (e - rexp));
        b = t >>> (((e - te) > 62) ? 62 : (e - te));
        s = a + b;
        if (s > MMAX || s < MMIN) begin s = s >>> 1; e++; end
        if (s == 0) e = 0;
        racc = s;
        rexp = e;
    endfunction

    function automatic longint dot_ref();
        longint s = 0;
        for (int i = 0; i < LANES; i++)
            s += longint'($signed(ta[i*MW +: MW])) * longint'($signed(tb[i*MW +: MW]));
        return s;
    endfunction

    task automatic step(input bit v, input bit last, input int ea, input int eb, input bit ordy);
        bit adv;
        longint t;
        @(negedge clk);
        chk(out_valid == eov, "out_valid", out_valid, eov);
        if (eov) begin
            chk($signed(out_mant) == em, "out_mant", $signed(out_mant), em);
            chk($signed(out_exp) == ee, "out_exp", $signed(out_exp), ee);
            chk($signed(out_tile_sum) == et, "out_tile_sum", $signed(out_tile_sum), et);
        end
        in_valid  = v;
        in_last   = last;
        in_exp_a  = ea[EW-1:0];
        in_exp_b  = eb[EW-1:0];
        in_mant_a = ta;
        in_mant_b = tb;
        out_ready = ordy;
        #1;
        adv = !(eov && !ordy);
        chk(in_ready == adv, "in_ready", in_ready, adv);
        t = dot_ref();
        if (adv) begin
            if (ms1_v) fold(ms1_sum, ms1_exp);
            eov = ms1_v && ms1_last;
            if (eov) begin
                em = racc; ee = rexp; et = ms1_sum;
                racc = 0; rexp = 0;
            end
            ms1_v = v;
            if (v) begin ms1_sum = t; ms1_exp = ea + eb; ms1_last = last; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
    endtask

    task automatic fill(input int va, input int vb);
        for (int i = 0; i < LANES; i++) begin
            ta[i*MW +: MW] = va[MW-1:0];
            tb[i*MW +: MW] = vb[MW-1:0];
        end
    endtask

    task automatic fill_rand();
        for (int i = 0; i < LANES; i++) begin
            ta[i*MW +: MW] = MW'($urandom);
            tb[i*MW +: MW] = MW'($urandom);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R10";
        idle(2);

        // R1 R2 R7: single-tile vector with a ramp, taken over exactly
        cur_req = "R1";
        for (int i = 0; i < LANES; i++) begin
            ta[i*MW +: MW] = MW'(i - 11);
            tb[i*MW +: MW] = MW'(3 - i);
        end
        step(1, 1, 5, -9, 1);
        cur_req = "R2";
        idle(3);

        // R3: extreme lanes, all most-negative times most-negative
        cur_req = "R3";
        fill(-128, -128);
        step(1, 1, 0, 0, 1);
        fill(-128, 127);
        step(1, 1, 1, 1, 1);
        idle(3);

        // R4: tiles at different exponents are aligned before adding
        cur_req = "R4";
        fill(37, -5);  step(1, 0, 3, 0, 1);
        fill(-19, 7);  step(1, 0, 0, -2, 1);
        fill(100, 90); step(1, 1, -20, -30, 1);
        idle(3);

        // R5: repeated extreme tiles push the running mantissa past its range
        cur_req = "R5";
        fill(-128, -128);
        for (int k = 0; k < 12; k++) step(1, k == 11, 0, 0, 1);
        idle(3);

        // R6: a zero tile with an odd exponent in the middle changes nothing
        cur_req = "R6";
        fill(12, 13);  step(1, 0, 2, 2, 1);
        fill(0, 55);   step(1, 0, 100, 100, 1);
        fill(-3, 9);   step(1, 1, 1, 1, 1);
        idle(3);

        // R7: cancellation to zero reports exponent zero, then refills
        cur_req = "R7";
        fill(44, 21);  step(1, 0, 6, -1, 1);
        fill(-44, 21); step(1, 1, 6, -1, 1);
        fill(9, 9);    step(1, 0, 4, 4, 1);
        fill(-9, 9);   step(1, 0, 4, 4, 1);
        fill(2, 3);    step(1, 1, -7, 2, 1);
        idle(3);

        // R8: back-to-back vectors; the second must start from zero
        cur_req = "R8";
        fill(50, 50);  step(1, 1, 0, 0, 1);
        fill(-1, 1);   step(1, 1, 0, 0, 1);
        idle(3);

        // R9: hold the result while tiles keep being offered
        cur_req = "R9";
        fill(7, -8);   step(1, 1, 1, 2, 1);
        fill(11, 3);   step(1, 1, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 1);
        idle(4);

        // R1 R4 R5: random vectors of random length and exponents
        cur_req = "R1";
        for (int v = 0; v < 40; v++) begin
            int len;
            len = 1 + ($urandom % 6);
            for (int k = 0; k < len; k++) begin
                fill_rand();
                step(1, k == len - 1, int'($urandom % 41) - 20, int'($urandom % 41) - 20,
                     ($urandom % 4) != 0);
            end
        end
        idle(6);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule